// File: doc/BRIEF.md
# Multi-Lane Link Test Pattern Generator and Checker

This block exercises a set of parallel, synchronous serial lanes with known traffic. Each lane transmits one 32-bit word per clock. A data word carries a 24-bit running count in its upper bits and an 8-bit check byte in its lowest bits. A shared bunch-crossing counter steps through a fixed orbit. While that counter sits on two configured consecutive positions of the orbit's empty stretch, every lane sends a fixed realignment word, marked by a control flag, instead of data.

On the receive side, every lane has its own checker that sees whatever came back from the far end. The checker tests the check byte of each data word and tracks that the count advances by one per word. After a realignment word, it takes the next data word as a fresh reference. It keeps separate counts of accepted words, faulty words, realignments arriving where the schedule expects them (the send window shifted by the link's latency), and realignments arriving anywhere else.

Streaming rules: the transmit side carries no valid or ready signal, because a synchronous link cannot pause and a word leaves on every clock. The receive side has a per-lane valid and no ready. The checker accepts every beat whose valid is high, so it never applies back-pressure. A beat with valid low is ignored.

Top module: `lpt_link_test`

## Requirements
- R1: The bunch counter `bc_count` is 0 in the first cycle after reset, rises by one per clock, and returns to 0 after ORBIT_LEN-1.
- R2: A data word on any lane has `tx_ctrl` low, bits [31:8] holding the payload and bits [7:0] equal to the XOR of payload bits [23:16], [15:8] and [7:0].
- R3: The transmitted payload is 0 after reset. It rises by one (modulo 2^24) after each data word and holds still across realignment words.
- R4: In the cycles where `bc_count` equals GAP_START or GAP_START+1, every lane drives `tx_ctrl` high with `tx_word` equal to COMMA (default 32'h3CBC_F7BC). `tx_ctrl` is low in every other cycle.
- R5: Each lane's `word_cnt` rises by one for every beat with `rx_valid` high. A beat with `rx_valid` low changes no counter and no lane state.
- R6: A received beat with `rx_ctrl` low and a wrong check byte, or with `rx_ctrl` high and a word other than COMMA, adds one to `err_cnt` and sets the sticky `err_flag`. The expected payload then steps by one.
- R7: A data word with a correct check byte whose payload differs from the expected value adds one to `err_cnt` and sets `err_flag`. The lane then expects that received payload plus one.
- R8: After a COMMA is received, the next valid data word is taken as the new payload reference, with no continuity error.
- R9: A received COMMA adds one to `realign_cnt` when `bc_count` equals (GAP_START+LINK_DELAY) or (GAP_START+LINK_DELAY+1), both modulo ORBIT_LEN. Otherwise it adds one to `unexp_cnt`.
- R10: A synchronous active-high `rst` zeroes all counters, clears `err_flag`, sets the expected payload to 0 and restarts the orbit.
- R11: Lanes are checked independently. Faults on one lane leave the other lanes' counters and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| bc_count | output | $clog2(ORBIT_LEN) | Bunch-crossing position within the orbit |
| tx_ctrl | output | LANES | Per-lane control flag, high on realignment words |
| tx_word | output | LANES*32 | Per-lane transmitted word, lane i at bits [32i+31:32i] |
| rx_valid | input | LANES | Per-lane receive beat valid |
| rx_ctrl | input | LANES | Per-lane received control flag |
| rx_word | input | LANES*32 | Per-lane received word |
| word_cnt | output | LANES*32 | Accepted beats per lane |
| err_cnt | output | LANES*32 | Faulty words per lane |
| realign_cnt | output | LANES*32 | Realignments received inside the expected window |
| unexp_cnt | output | LANES*32 | Realignments received outside the window |
| err_flag | output | LANES | Sticky per-lane error indicator |

## Verification
The bound checker watches the cycle-level rules on every clock:
- the orbit stepping and wrap;
- the check byte and payload step of every transmitted data word;
- the realignment word's value, the cycle it starts in, and that all lanes switch to it together;
- counters holding on idle beats and rising by at most one per beat;
- the sticky flag;
- counters being clear after reset.

Only the bench's scenarios show whether each kind of injected fault is classified correctly. It loops back the transmit stream through a two-cycle delay and, on one lane, injects at known points:
- a flipped payload bit;
- a flipped check bit;
- a flagged non-realignment word;
- a dropped beat;
- a stray realignment word;
- two payload jumps, one right after a scheduled realignment and one not.

The bench then shows the exact counts these produce and that the clean lane stays at zero errors.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int PAY_W  = 24;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 32;

  function automatic logic [7:0] pay_sum(input logic [PAY_W-1:0] p);
    return p[23:16] ^ p[15:8] ^ p[7:0];
  endfunction

  function automatic logic [WORD_W-1:0] pack_data(input logic [PAY_W-1:0] p);
    return {p, pay_sum(p)};
  endfunction
endpackage

// File: rtl/lpt_bx_sched.sv
module lpt_bx_sched #(
  parameter int ORBIT_LEN  = 3564,
  parameter int GAP_START  = 3500,
  parameter int LINK_DELAY = 0,
  parameter int BC_W       = $clog2(ORBIT_LEN)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [BC_W-1:0] bc,
  output logic            tx_gap,
  output logic            rx_gap
);
  localparam int LAST  = ORBIT_LEN - 1;
  localparam int TX_G0 = GAP_START % ORBIT_LEN;
  localparam int TX_G1 = (GAP_START + 1) % ORBIT_LEN;
  localparam int RX_G0 = (GAP_START + LINK_DELAY) % ORBIT_LEN;
  localparam int RX_G1 = (GAP_START + LINK_DELAY + 1) % ORBIT_LEN;

  always_ff @(posedge clk) begin
    if (rst)                     bc <= '0;
    else if (bc == BC_W'(LAST))  bc <= '0;
    else                         bc <= bc + 1'b1;
  end

  assign tx_gap = (bc == BC_W'(TX_G0)) || (bc == BC_W'(TX_G1));
  assign rx_gap = (bc == BC_W'(RX_G0)) || (bc == BC_W'(RX_G1));
endmodule

// File: rtl/lpt_tx_lane.sv
module lpt_tx_lane
  import lpt_pkg::*;
#(
  parameter logic [WORD_W-1:0] COMMA = 32'h3CBC_F7BC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gap,
  output logic              ctrl,
  output logic [WORD_W-1:0] word
);
  logic [PAY_W-1:0] pay_q;

  always_ff @(posedge clk) begin
    if (rst)       pay_q <= '0;
    else if (!gap) pay_q <= pay_q + 1'b1;
  end

  assign ctrl = gap;
  assign word = gap ? COMMA : pack_data(pay_q);
endmodule

// File: rtl/lpt_rx_lane.sv
module lpt_rx_lane
  import lpt_pkg::*;
#(
  parameter logic [WORD_W-1:0] COMMA = 32'h3CBC_F7BC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_ctrl,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_window,
  output logic [CNT_W-1:0]  word_cnt,
  output logic [CNT_W-1:0]  err_cnt,
  output logic [CNT_W-1:0]  realign_cnt,
  output logic [CNT_W-1:0]  unexp_cnt,
  output logic              err_flag
);
  logic [PAY_W-1:0] exp_q;
  logic             resync_q;

  logic             is_comma, corrupt, disc;
  logic [PAY_W-1:0] pay;

  always_comb begin
    pay      = in_word[WORD_W-1:8];
    is_comma = in_ctrl && (in_word == COMMA);
    corrupt  = in_ctrl ? !is_comma : (in_word[7:0] != pay_sum(pay));
    disc     = !in_ctrl && !corrupt && !resync_q && (pay != exp_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q       <= '0;
      resync_q    <= 1'b0;
      word_cnt    <= '0;
      err_cnt     <= '0;
      realign_cnt <= '0;
      unexp_cnt   <= '0;
      err_flag    <= 1'b0;
    end else if (in_valid) begin
      word_cnt <= word_cnt + 1'b1;
      if (is_comma) begin
        resync_q <= 1'b1;
        if (in_window) realign_cnt <= realign_cnt + 1'b1;
        else           unexp_cnt   <= unexp_cnt + 1'b1;
      end else if (corrupt) begin
        exp_q    <= exp_q + 1'b1;
        err_cnt  <= err_cnt + 1'b1;
        err_flag <= 1'b1;
      end else begin
        exp_q    <= pay + 1'b1;
        resync_q <= 1'b0;
        if (disc) begin
          err_cnt  <= err_cnt + 1'b1;
          err_flag <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lpt_link_test.sv
module lpt_link_test
  import lpt_pkg::*;
#(
  parameter int                LANES      = 4,
  parameter int                ORBIT_LEN  = 3564,
  parameter int                GAP_START  = 3500,
  parameter int                LINK_DELAY = 0,
  parameter logic [WORD_W-1:0] COMMA      = 32'h3CBC_F7BC,
  localparam int               BC_W       = $clog2(ORBIT_LEN)
) (
  input  logic                    clk,
  input  logic                    rst,
  output logic [BC_W-1:0]         bc_count,
  output logic [LANES-1:0]        tx_ctrl,
  output logic [LANES*WORD_W-1:0] tx_word,
  input  logic [LANES-1:0]        rx_valid,
  input  logic [LANES-1:0]        rx_ctrl,
  input  logic [LANES*WORD_W-1:0] rx_word,
  output logic [LANES*CNT_W-1:0]  word_cnt,
  output logic [LANES*CNT_W-1:0]  err_cnt,
  output logic [LANES*CNT_W-1:0]  realign_cnt,
  output logic [LANES*CNT_W-1:0]  unexp_cnt,
  output logic [LANES-1:0]        err_flag
);
  logic tx_gap, rx_gap;

  lpt_bx_sched #(
    .ORBIT_LEN(ORBIT_LEN), .GAP_START(GAP_START),
    .LINK_DELAY(LINK_DELAY), .BC_W(BC_W)
  ) u_sched (
    .clk(clk), .rst(rst), .bc(bc_count), .tx_gap(tx_gap), .rx_gap(rx_gap)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    lpt_tx_lane #(.COMMA(COMMA)) u_tx (
      .clk(clk), .rst(rst), .gap(tx_gap),
      .ctrl(tx_ctrl[i]), .word(tx_word[i*WORD_W +: WORD_W])
    );
    lpt_rx_lane #(.COMMA(COMMA)) u_rx (
      .clk(clk), .rst(rst),
      .in_valid(rx_valid[i]), .in_ctrl(rx_ctrl[i]),
      .in_word(rx_word[i*WORD_W +: WORD_W]), .in_window(rx_gap),
      .word_cnt(word_cnt[i*CNT_W +: CNT_W]),
      .err_cnt(err_cnt[i*CNT_W +: CNT_W]),
      .realign_cnt(realign_cnt[i*CNT_W +: CNT_W]),
      .unexp_cnt(unexp_cnt[i*CNT_W +: CNT_W]),
      .err_flag(err_flag[i])
    );
  end
endmodule

// File: rtl/lpt_link_test_chk.sv
module lpt_link_test_chk
  import lpt_pkg::*;
#(
  parameter int                LANES      = 4,
  parameter int                ORBIT_LEN  = 3564,
  parameter int                GAP_START  = 3500,
  parameter logic [WORD_W-1:0] COMMA      = 32'h3CBC_F7BC,
  parameter int                BC_W       = $clog2(ORBIT_LEN)
) (
  input logic                    clk,
  input logic                    rst,
  input logic [BC_W-1:0]         bc_count,
  input logic [LANES-1:0]        tx_ctrl,
  input logic [LANES*WORD_W-1:0] tx_word,
  input logic [LANES-1:0]        rx_valid,
  input logic [LANES*CNT_W-1:0]  word_cnt,
  input logic [LANES*CNT_W-1:0]  err_cnt,
  input logic [LANES*CNT_W-1:0]  realign_cnt,
  input logic [LANES*CNT_W-1:0]  unexp_cnt,
  input logic [LANES-1:0]        err_flag
);
  // R1
  bc_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(bc_count) < ORBIT_LEN);

  // R1
  bc_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> int'(bc_count) == ((int'($past(bc_count)) + 1) % ORBIT_LEN));

  // R4
  gap_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_ctrl[0]) |-> int'(bc_count) == (GAP_START % ORBIT_LEN));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    // R4
    comma_value_chk: assert property (@(posedge clk) disable iff (rst)
      tx_ctrl[i] |-> tx_word[i*WORD_W +: WORD_W] == COMMA);

    // R4
    lane_align_chk: assert property (@(posedge clk) disable iff (rst)
      tx_ctrl[i] == tx_ctrl[0]);

    // R2
    data_sum_chk: assert property (@(posedge clk) disable iff (rst)
      !tx_ctrl[i] |-> tx_word[i*WORD_W +: 8] ==
        (tx_word[i*WORD_W+24 +: 8] ^ tx_word[i*WORD_W+16 +: 8] ^ tx_word[i*WORD_W+8 +: 8]));

    // R3
    pay_step_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!tx_ctrl[i]) && !tx_ctrl[i]) |->
        tx_word[i*WORD_W+8 +: PAY_W] == $past(tx_word[i*WORD_W+8 +: PAY_W]) + 1'b1);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !rx_valid[i] |=> ($stable(word_cnt[i*CNT_W +: CNT_W]) &&
                        $stable(err_cnt[i*CNT_W +: CNT_W]) &&
                        $stable(realign_cnt[i*CNT_W +: CNT_W]) &&
                        $stable(unexp_cnt[i*CNT_W +: CNT_W])));

    // R6
    err_step_chk: assert property (@(posedge clk) disable iff (rst)
      $past(!rst) |-> (err_cnt[i*CNT_W +: CNT_W] == $past(err_cnt[i*CNT_W +: CNT_W]) ||
                       err_cnt[i*CNT_W +: CNT_W] == $past(err_cnt[i*CNT_W +: CNT_W]) + 1'b1));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(err_flag[i])) |-> err_flag[i]);

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (word_cnt[i*CNT_W +: CNT_W] == '0 && err_cnt[i*CNT_W +: CNT_W] == '0 &&
                      realign_cnt[i*CNT_W +: CNT_W] == '0 && unexp_cnt[i*CNT_W +: CNT_W] == '0 &&
                      !err_flag[i]));
  end
endmodule

bind lpt_link_test lpt_link_test_chk #(
  .LANES(LANES), .ORBIT_LEN(ORBIT_LEN), .GAP_START(GAP_START),
  .COMMA(COMMA), .BC_W(BC_W)
) u_chk (
  .clk(clk), .rst(rst), .bc_count(bc_count), .tx_ctrl(tx_ctrl), .tx_word(tx_word),
  .rx_valid(rx_valid), .word_cnt(word_cnt), .err_cnt(err_cnt),
  .realign_cnt(realign_cnt), .unexp_cnt(unexp_cnt), .err_flag(err_flag)
);

// File: tb/sim_lpt_link_test.sv
module sim_lpt_link_test;
  localparam int LN = 2;
  localparam int OL = 16;
  localparam int GS = 10;
  localparam int LD = 2;
  localparam logic [31:0] CM = 32'h3CBC_F7BC;
  localparam int NCYC = LD + 8 * OL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]       bc_count;
  logic [LN-1:0]    tx_ctrl, rx_valid, rx_ctrl, err_flag;
  logic [LN*32-1:0] tx_word, rx_word, word_cnt, err_cnt, realign_cnt, unexp_cnt;

  lpt_link_test #(.LANES(LN), .ORBIT_LEN(OL), .GAP_START(GS), .LINK_DELAY(LD), .COMMA(CM)) u0 (
    .clk(clk), .rst(rst), .bc_count(bc_count), .tx_ctrl(tx_ctrl), .tx_word(tx_word),
    .rx_valid(rx_valid), .rx_ctrl(rx_ctrl), .rx_word(rx_word),
    .word_cnt(word_cnt), .err_cnt(err_cnt), .realign_cnt(realign_cnt),
    .unexp_cnt(unexp_cnt), .err_flag(err_flag)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  function automatic logic [31:0] mk(input logic [23:0] p);
    return {p, p[23:16] ^ p[15:8] ^ p[7:0]};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_counters(input string tag, input int l, input int w, input int e,
                              input int r, input int u);
    chk({"R5 word_cnt ", tag}, word_cnt[l*32 +: 32], w);
    chk({"R6 R7 err_cnt ", tag}, err_cnt[l*32 +: 32], e);
    chk({"R9 realign_cnt ", tag}, realign_cnt[l*32 +: 32], r);
    chk({"R9 unexp_cnt ", tag}, unexp_cnt[l*32 +: 32], u);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  logic        q_v [LN][0:LD];
  logic        q_c [LN][0:LD];
  logic [31:0] q_w [LN][0:LD];
  int w_exp [LN];
  int e_exp [LN];
  int r_exp [LN];
  int u_exp [LN];

  initial begin
    logic [23:0] pm;
    logic [23:0] off;
    pm = '0;
    off = '0;
    rx_valid = '0;
    rx_ctrl  = '0;
    rx_word  = '0;
    for (int l = 0; l < LN; l++) begin
      w_exp[l] = 0; e_exp[l] = 0; r_exp[l] = 0; u_exp[l] = 0;
      for (int k = 0; k <= LD; k++) begin
        q_v[l][k] = 1'b0; q_c[l][k] = 1'b0; q_w[l][k] = '0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: state right after reset
    chk("R10 bc after reset", bc_count, 0);
    for (int l = 0; l < LN; l++) begin
      chk_counters("R10 after reset", l, 0, 0, 0, 0);
      chk("R10 err_flag after reset", err_flag[l], 0);
    end

    for (int n = 0; n < NCYC; n++) begin
      int  b;
      bit  gap;
      b   = n % OL;
      gap = (b == GS) || (b == GS + 1);
      // R1 orbit position
      chk("R1 bc_count", bc_count, b);
      for (int l = 0; l < LN; l++) begin
        // R4 realignment schedule, R2/R3 data format and payload
        chk("R4 tx_ctrl", tx_ctrl[l], gap);
        chk(gap ? "R4 tx comma" : "R2 R3 tx data", tx_word[l*32 +: 32], gap ? CM : mk(pm));
        // R11 lane 0 is never disturbed
        chk_counters(l == 0 ? "R11 clean lane" : "faulted lane", l,
                     w_exp[l], e_exp[l], r_exp[l], u_exp[l]);
      end
      // loopback delay line fed from the transmit outputs
      for (int l = 0; l < LN; l++) begin
        for (int k = LD; k > 0; k--) begin
          q_v[l][k] = q_v[l][k-1]; q_c[l][k] = q_c[l][k-1]; q_w[l][k] = q_w[l][k-1];
        end
        q_v[l][0] = 1'b1; q_c[l][0] = tx_ctrl[l]; q_w[l][0] = tx_word[l*32 +: 32];
      end
      for (int l = 0; l < LN; l++) begin
        logic        v, c;
        logic [31:0] w;
        int          s, so, sb;
        bit          src_comma;
        v = q_v[l][LD]; c = q_c[l][LD]; w = q_w[l][LD];
        s = n - LD; so = s / OL; sb = s % OL;
        src_comma = v && ((sb == GS) || (sb == GS + 1));
        if (v && l == 1) begin
          // R8: payload jump right after a scheduled realignment, no error
          if (so == 6 && sb == GS + 2) off = off + 24'd100;
          // R7: payload jump with good check byte, one error
          if (so == 5 && sb == 8) begin off = off + 24'd5; e_exp[l]++; end
          if (!src_comma) w = mk(w[31:8] + off);
          // R6: payload bit 3 flipped (word bit 11)
          if (so == 3 && sb == 2) begin w = w ^ 32'h0000_0800; e_exp[l]++; end
          // R6: check bit 0 flipped
          if (so == 3 && sb == 5) begin w = w ^ 32'h0000_0001; e_exp[l]++; end
          // R6: control flag on a non-comma word
          if (so == 4 && sb == 3) begin c = 1'b1; e_exp[l]++; end
          // R5: dropped beat; R7: next word is discontinuous
          if (so == 4 && sb == 7) v = 1'b0;
          if (so == 4 && sb == 8) e_exp[l]++;
          // R9: stray comma outside the window
          if (so == 5 && sb == 4) begin c = 1'b1; w = CM; u_exp[l]++; end
        end
        if (v) w_exp[l]++;
        if (src_comma) r_exp[l]++;
        rx_valid[l] = v;
        rx_ctrl[l]  = c;
        rx_word[l*32 +: 32] = w;
      end
      if (!gap) pm = pm + 1'b1;
      @(negedge clk);
    end

    // R6 sticky flag on the faulted lane only (R11)
    chk("R6 err_flag lane1", err_flag[1], 1);
    chk("R11 err_flag lane0", err_flag[0], 0);
    chk("R7 total errors lane1", err_cnt[32 +: 32], 5);
    chk("R9 total stray lane1", unexp_cnt[32 +: 32], 1);

    // R10: mid-run reset clears everything
    rst = 1'b1;
    rx_valid = '0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R10 bc after rerun reset", bc_count, 0);
    for (int l = 0; l < LN; l++) begin
      chk_counters("R10 after rerun reset", l, 0, 0, 0, 0);
      chk("R10 err_flag cleared", err_flag[l], 0);
      chk("R10 R3 payload restart", tx_word[l*32 +: 32], mk(24'd0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule